// File: doc/BRIEF.md
# Wrapping Hardware Stack Engine

This block is the byte-wide hardware stack of a small 8-bit processor core. It keeps a 16-bit stack pointer whose upper byte is fixed at 01h, so every stack access lands in a single 256-byte page that is held in a local memory. The core issues single-byte push and pop requests. It can also return the pointer to the top of the page with a reset-pointer command, or load the pointer's low byte directly. The low byte is always visible on the pointer output, so software can read it back as an ordinary data byte.

A push stores its byte at the address the pointer holds and then moves the pointer down. A pop first moves the pointer up and then reads the byte there. When the pointer runs past either end of the page it wraps around with no indication. Older bytes are then overwritten, and later pops return whatever was written last. For interrupt entry the block saves five context bytes on its own, starting with the program counter's low byte. A matching restore pops those bytes back in reverse order and shows each one on the pop data output.

Top module: `stack_engine`

## Requirements
- R1: After reset the pointer reads 01FFh, and busy, pop-valid and error are all low.
- R2: The pointer's upper byte always reads 01h, whatever the operation or load value.
- R3: A push writes its byte at the current pointer address and the pointer then reads one lower on the next cycle.
- R4: A pop makes the pointer read one higher on the next cycle. In that same cycle pop_valid_o is high and pop_data_o holds the byte stored at the new pointer address.
- R5: The low byte wraps modulo 256 in both directions with no flag: a push at 00h gives FFh and a pop at FFh gives 00h. A byte overwritten through wrapping is the one that later pops return.
- R6: A reset-pointer command sets the low byte to FFh on the next cycle. It takes priority over push, pop, direct load and a running context sequence, which it cancels.
- R7: A direct load places ld_data_i in the pointer's low byte on the next cycle, and the value reads back on sp_o[7:0]. A load wins over a push or pop in the same cycle.
- R8: A push and a pop requested together in the same cycle are both ignored. err_o is then high for exactly the following cycle, and the pointer stays unchanged.
- R9: A context save request makes busy_o high for five cycles. During those cycles the block pushes one byte per clock, in the order PCL, PCH, X, A, CC. The bytes are captured in the request cycle, and the pointer ends five lower.
- R10: A context restore request keeps busy_o high for five cycles and pops one byte per clock. The bytes come out on pop_data_o in the order CC, A, X, PCH, PCL, and the pointer ends five higher.
- R11: While busy_o is high, push, pop, direct load and further context requests are ignored. Only the reset-pointer command acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push one byte |
| pop_i | input | 1 | Pop one byte |
| push_data_i | input | 8 | Byte to push |
| ld_i | input | 1 | Load the pointer low byte directly |
| ld_data_i | input | 8 | Value for the direct load |
| rsp_i | input | 1 | Return the pointer to the top of the stack |
| ctx_save_i | input | 1 | Start the five-byte context save |
| ctx_restore_i | input | 1 | Start the five-byte context restore |
| pcl_i | input | 8 | Program counter low byte to save |
| pch_i | input | 8 | Program counter high byte to save |
| x_i | input | 8 | Index register byte to save |
| a_i | input | 8 | Accumulator byte to save |
| cc_i | input | 8 | Condition-code byte to save |
| sp_o | output | 16 | Full stack pointer |
| pop_data_o | output | 8 | Registered popped byte |
| pop_valid_o | output | 1 | pop_data_o is valid this cycle |
| busy_o | output | 1 | Context sequence in progress |
| err_o | output | 1 | One-cycle pulse after a push and a pop in the same cycle |

## Verification
The assertions assume that the reset-pointer command is not asserted during a context sequence. The busy-window check relies on that. They also assume that the outputs are judged only after reset has been released. The stimulus keeps rsp_i low while busy_o is high and changes every input only at the falling edge. A pop is never issued at an address that has not yet been written, so every returned byte has a known expected value. The wrap test pushes more than 256 bytes before it pops anything, so every address has been written at least once.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_PUSH,
      OP_POP,
      OP_LOAD,
      OP_RESET
   } stk_op_e;
endpackage

// File: rtl/stk_ctx_seq.sv
module stk_ctx_seq #(
   parameter int DATA_W    = 8,
   parameter int CTX_BYTES = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rsp_i,
   input  logic                          save_i,
   input  logic                          restore_i,
   input  logic [CTX_BYTES*DATA_W-1:0]   ctx_i,
   output logic                          start_o,
   output logic                          busy_o,
   output logic                          is_save_o,
   output logic [DATA_W-1:0]             byte_o
);
   localparam int IDX_W = (CTX_BYTES > 1) ? $clog2(CTX_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CTX_BYTES - 1);

   logic                        busy_q;
   logic                        save_q;
   logic [IDX_W-1:0]            idx_q;
   logic [CTX_BYTES*DATA_W-1:0] ctx_q;

   assign start_o   = !busy_q && !rsp_i && (save_i || restore_i);
   assign busy_o    = busy_q;
   assign is_save_o = save_q;
   assign byte_o    = ctx_q[idx_q*DATA_W +: DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         save_q <= 1'b0;
         idx_q  <= '0;
         ctx_q  <= '0;
      end else if (rsp_i) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (start_o) begin
         busy_q <= 1'b1;
         save_q <= save_i;
         idx_q  <= '0;
         ctx_q  <= ctx_i;
      end else if (busy_q) begin
         if (idx_q == LAST) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> busy_o);
   a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && idx_q == LAST && !rsp_i) |=> !busy_o);
   a_r6_rsp_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_i |=> !busy_o);
endmodule

// File: rtl/stk_arb.sv
module stk_arb
   import stk_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rsp_i,
   input  logic              busy_i,
   input  logic              start_i,
   input  logic              seq_save_i,
   input  logic [DATA_W-1:0] seq_byte_i,
   input  logic              ld_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] push_data_i,
   output stk_op_e           op_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              conflict_o
);
   always_comb begin
      op_o       = OP_IDLE;
      wdata_o    = push_data_i;
      conflict_o = 1'b0;
      if (rsp_i) begin
         op_o = OP_RESET;
      end else if (busy_i) begin
         op_o    = seq_save_i ? OP_PUSH : OP_POP;
         wdata_o = seq_byte_i;
      end else if (start_i) begin
         op_o = OP_IDLE;
      end else if (ld_i) begin
         op_o    = OP_LOAD;
         wdata_o = ld_data_i;
      end else if (push_i && pop_i) begin
         conflict_o = 1'b1;
      end else if (push_i) begin
         op_o = OP_PUSH;
      end else if (pop_i) begin
         op_o = OP_POP;
      end
   end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
   import stk_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_op_e           op_i,
   input  logic [ADDR_W-1:0] ld_data_i,
   output logic [ADDR_W-1:0] lo_o
);
   logic [ADDR_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '1;
      end else begin
         case (op_i)
            OP_RESET: lo_q <= '1;
            OP_PUSH:  lo_q <= lo_q - 1'b1;
            OP_POP:   lo_q <= lo_q + 1'b1;
            OP_LOAD:  lo_q <= ld_data_i;
            default:  lo_q <= lo_q;
         endcase
      end
   end

   assign lo_o = lo_q;

   a_r3_push_down: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_PUSH |=> lo_o == $past(lo_o) - 1'b1);
   a_r4_pop_up: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_POP |=> lo_o == $past(lo_o) + 1'b1);
   a_r5_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_PUSH && lo_o == '0) |=> lo_o == '1);
   a_r5_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_POP && lo_o == '1) |=> lo_o == '0);
   a_r6_rsp_top: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_RESET |=> lo_o == '1);
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == OP_LOAD |=> lo_o == $past(ld_data_i));
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= re_i;
         if (re_i) rdata_o <= mem[raddr_i];
      end
   end

   a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      re_i |=> rvalid_o);
   a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !re_i |=> !rvalid_o);
endmodule

// File: rtl/stack_engine.sv
module stack_engine
   import stk_pkg::*;
#(
   parameter int                 DATA_W  = 8,
   parameter int                 ADDR_W  = 8,
   parameter int                 SP_W    = 16,
   parameter logic [SP_W-ADDR_W-1:0] PAGE_HI = 'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              ld_i,
   input  logic [ADDR_W-1:0] ld_data_i,
   input  logic              rsp_i,
   input  logic              ctx_save_i,
   input  logic              ctx_restore_i,
   input  logic [DATA_W-1:0] pcl_i,
   input  logic [DATA_W-1:0] pch_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] cc_i,
   output logic [SP_W-1:0]   sp_o,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              pop_valid_o,
   output logic              busy_o,
   output logic              err_o
);
   localparam int CTX_BYTES = 5;

   if (SP_W <= ADDR_W) begin : g_bad_sp_w
      $error("stack_engine: SP_W must exceed ADDR_W");
   end
   if (DATA_W != ADDR_W) begin : g_bad_dw
      $error("stack_engine: direct load needs DATA_W equal to ADDR_W");
   end

   stk_op_e           op;
   logic [DATA_W-1:0] wdata;
   logic              conflict;
   logic              seq_start, seq_busy, seq_save;
   logic [DATA_W-1:0] seq_byte;
   logic [ADDR_W-1:0] sp_lo;
   logic              err_q;
   logic [CTX_BYTES*DATA_W-1:0] ctx_bus;

   assign ctx_bus = {cc_i, a_i, x_i, pch_i, pcl_i};

   stk_ctx_seq #(.DATA_W(DATA_W), .CTX_BYTES(CTX_BYTES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsp_i     (rsp_i),
      .save_i    (ctx_save_i),
      .restore_i (ctx_restore_i),
      .ctx_i     (ctx_bus),
      .start_o   (seq_start),
      .busy_o    (seq_busy),
      .is_save_o (seq_save),
      .byte_o    (seq_byte)
   );

   stk_arb #(.DATA_W(DATA_W)) u_arb (
      .rsp_i       (rsp_i),
      .busy_i      (seq_busy),
      .start_i     (seq_start),
      .seq_save_i  (seq_save),
      .seq_byte_i  (seq_byte),
      .ld_i        (ld_i),
      .ld_data_i   (ld_data_i),
      .push_i      (push_i),
      .pop_i       (pop_i),
      .push_data_i (push_data_i),
      .op_o        (op),
      .wdata_o     (wdata),
      .conflict_o  (conflict)
   );

   stk_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op),
      .ld_data_i (wdata),
      .lo_o      (sp_lo)
   );

   stk_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (op == OP_PUSH),
      .waddr_i  (sp_lo),
      .wdata_i  (wdata),
      .re_i     (op == OP_POP),
      .raddr_i  (sp_lo + 1'b1),
      .rdata_o  (pop_data_o),
      .rvalid_o (pop_valid_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= conflict;
   end

   assign err_o  = err_q;
   assign busy_o = seq_busy;
   assign sp_o   = {PAGE_HI, sp_lo};

   a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(push_i && pop_i));
   a_r8_conflict_holds_sp: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> sp_o == $past(sp_o));
   a_r11_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !rsp_i) |=> (sp_o[ADDR_W-1:0] == ADDR_W'($past(sp_o[ADDR_W-1:0]) - 1'b1)) ||
                             (sp_o[ADDR_W-1:0] == ADDR_W'($past(sp_o[ADDR_W-1:0]) + 1'b1)));
endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 0, pop_i = 0, ld_i = 0, rsp_i = 0;
   logic        ctx_save_i = 0, ctx_restore_i = 0;
   logic [7:0]  push_data_i = 0, ld_data_i = 0;
   logic [7:0]  pcl_i = 0, pch_i = 0, x_i = 0, a_i = 0, cc_i = 0;
   logic [15:0] sp_o;
   logic [7:0]  pop_data_o;
   logic        pop_valid_o, busy_o, err_o;

   int checks = 0;
   int fails  = 0;
   logic [7:0] ref_sp;
   logic [7:0] model [256];

   always #2.5 clk = ~clk;

   stack_engine i_stack_engine (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .push_data_i(push_data_i), .ld_i(ld_i), .ld_data_i(ld_data_i),
      .rsp_i(rsp_i), .ctx_save_i(ctx_save_i), .ctx_restore_i(ctx_restore_i),
      .pcl_i(pcl_i), .pch_i(pch_i), .x_i(x_i), .a_i(a_i), .cc_i(cc_i),
      .sp_o(sp_o), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
      .busy_o(busy_o), .err_o(err_o));

   // fields: push pop ld rsp | din | exp_sp | exp_valid | exp_data | exp_err
   localparam int VW = 30;
   localparam logic [VW-1:0] VEC [12] = '{
      {4'b1000, 8'hAA, 8'hFE, 1'b0, 8'h00, 1'b0},
      {4'b1000, 8'hBB, 8'hFD, 1'b0, 8'h00, 1'b0},
      {4'b0100, 8'h00, 8'hFE, 1'b1, 8'hBB, 1'b0},
      {4'b1000, 8'hCC, 8'hFD, 1'b0, 8'h00, 1'b0},
      {4'b0100, 8'h00, 8'hFE, 1'b1, 8'hCC, 1'b0},
      {4'b0100, 8'h00, 8'hFF, 1'b1, 8'hAA, 1'b0},
      {4'b1100, 8'hDD, 8'hFF, 1'b0, 8'h00, 1'b1},
      {4'b0010, 8'h10, 8'h10, 1'b0, 8'h00, 1'b0},
      {4'b1010, 8'h20, 8'h20, 1'b0, 8'h00, 1'b0},
      {4'b1011, 8'h33, 8'hFF, 1'b0, 8'h00, 1'b0},
      {4'b1000, 8'h77, 8'hFE, 1'b0, 8'h00, 1'b0},
      {4'b0100, 8'h00, 8'hFF, 1'b1, 8'h77, 1'b0}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle();
      push_i = 0; pop_i = 0; ld_i = 0; rsp_i = 0;
      ctx_save_i = 0; ctx_restore_i = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      // R1 reset state
      check("R1 sp", sp_o, 16'h01FF);
      check("R1 busy", {15'd0, busy_o}, 16'd0);
      check("R1 valid", {15'd0, pop_valid_o}, 16'd0);
      check("R1 err", {15'd0, err_o}, 16'd0);

      // Table: R3 R4 R6 R7 R8
      foreach (VEC[i]) begin
         logic [VW-1:0] v;
         v = VEC[i];
         push_i = v[29]; pop_i = v[28]; ld_i = v[27]; rsp_i = v[26];
         push_data_i = v[25:18]; ld_data_i = v[25:18];
         step();
         idle();
         check("R3/R4/R6/R7 table sp", sp_o, {8'h01, v[17:10]});
         check("R4 table valid", {15'd0, pop_valid_o}, {15'd0, v[9]});
         if (v[9]) check("R4 table data", {8'h00, pop_data_o}, {8'h00, v[8:1]});
         check("R8 table err", {15'd0, err_o}, {15'd0, v[0]});
      end
      step();
      check("R8 err one cycle", {15'd0, err_o}, 16'd0);

      // R5 wrap: 300 pushes from top, then 256 pops
      ref_sp = 8'hFF;
      for (int k = 0; k < 300; k++) begin
         push_i = 1; push_data_i = 8'(k) ^ 8'h5A;
         model[ref_sp] = push_data_i;
         step();
         ref_sp = ref_sp - 8'd1;
         check("R5 wrap push sp", sp_o, {8'h01, ref_sp});
      end
      idle();
      for (int k = 0; k < 256; k++) begin
         pop_i = 1;
         step();
         ref_sp = ref_sp + 8'd1;
         check("R5 wrap pop sp", sp_o, {8'h01, ref_sp});
         check("R5 wrap pop data", {8'h00, pop_data_o}, {8'h00, model[ref_sp]});
      end
      idle();
      step();
      check("R4 valid drops", {15'd0, pop_valid_o}, 16'd0);

      // R2 / R7 load extremes
      ld_i = 1; ld_data_i = 8'h00;
      step(); idle();
      check("R2 R7 load 00", sp_o, 16'h0100);
      push_i = 1; push_data_i = 8'h99;
      step(); idle();
      check("R5 push at 00 wraps", sp_o, 16'h01FF);
      pop_i = 1;
      step(); idle();
      check("R5 pop at FF wraps", sp_o, 16'h0100);
      check("R5 pop wrap data", {8'h00, pop_data_o}, 16'h0099);
      rsp_i = 1; pop_i = 1;
      step(); idle();
      check("R6 rsp over pop", sp_o, 16'h01FF);
      check("R6 rsp pop ignored", {15'd0, pop_valid_o}, 16'd0);

      // R9 context save, R11 inputs ignored while busy
      pcl_i = 8'h11; pch_i = 8'h22; x_i = 8'h33; a_i = 8'h44; cc_i = 8'h55;
      ctx_save_i = 1;
      step(); idle();
      check("R9 busy after request", {15'd0, busy_o}, 16'd1);
      check("R9 sp at start", sp_o, 16'h01FF);
      pcl_i = 8'hEE; cc_i = 8'hEE;
      for (int k = 0; k < 5; k++) begin
         push_i = 1; push_data_i = 8'hF0; ld_i = 1; ld_data_i = 8'h40;
         ctx_restore_i = 1;
         step();
      end
      idle();
      check("R9 busy done", {15'd0, busy_o}, 16'd0);
      check("R9 R11 sp after save", sp_o, 16'h01FA);

      // R10 restore
      ctx_restore_i = 1;
      step(); idle();
      check("R10 busy after request", {15'd0, busy_o}, 16'd1);
      begin
         logic [7:0] exp_b [5];
         exp_b = '{8'h55, 8'h44, 8'h33, 8'h22, 8'h11};
         for (int k = 0; k < 5; k++) begin
            step();
            check("R10 restore valid", {15'd0, pop_valid_o}, 16'd1);
            check("R10 restore data", {8'h00, pop_data_o}, {8'h00, exp_b[k]});
         end
      end
      check("R10 busy done", {15'd0, busy_o}, 16'd0);
      check("R10 sp back", sp_o, 16'h01FF);
      check("R2 page fixed", {8'h00, sp_o[15:8]}, 16'h0001);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule